// File: doc/BRIEF.md
# GPIO Port Register Bank with Bit-Operation Aliases

This block is the register file of a general-purpose I/O port. It sits on a simple single-cycle memory-mapped bus and holds eight configuration and data registers of up to 16 bits. Software reads and writes them to drive pins, to choose per-pin direction, and to set up the interrupt masks and trigger options. The interrupt detection logic is a separate block, and it takes those settings from the `cfg_*` outputs.

Three of the registers (port data, interrupt mask A and interrupt mask B) each take up four consecutive bus slots. The first slot is a plain read/write. The other three let software clear, set or invert chosen bits in one write, so no read-modify-write is needed. Every bus request gets an acknowledge one cycle later. A request that has the wrong access size, or that falls outside the map, is flagged as an error and changes no state. The port's output pins carry the data bits gated by direction, and each pin has an output enable.

Top module: `gpio_rb`

## Requirements
- R1: Byte address bits [1:0] must be 0. The slot index is address/4. Slots 0,4,8 are the plain data, mask A and mask B registers. Slots 12..16 are direction, polarity, edge select, both-edges and input enable. A half-word write to a plain slot stores `req_wdata`, and a read returns the stored value.
- R2: A write to slot base+1 of a group (data, mask A, mask B) clears each base-register bit whose written bit is 1 and leaves the others unchanged.
- R3: A write to slot base+2 of a group ORs the written value into the base register.
- R4: A write to slot base+3 of a group XORs the written value into the base register.
- R5: A read of any of the three alias slots returns the current value of its group's base register.
- R6: Only half-word accesses are legal (`req_size` = 1; 0 = byte, 2 = word, 3 = reserved). Any other size gives `rsp_err`=1 and `rsp_size_err`=1, with no state change and `rsp_rdata`=0, even when the address is also unmapped.
- R7: A half-word access to a misaligned address, or to slot 17 or above, gives `rsp_err`=1 and `rsp_size_err`=0, with no state change and `rsp_rdata`=0.
- R8: `rsp_ack` is high for exactly the cycle after each cycle in which `req_valid` is high. `rsp_err` and `rsp_size_err` are high only together with `rsp_ack`. Read data is in `rsp_rdata` in that same cycle and is 0 for writes.
- R9: `pin_oe` equals the direction register, delayed by one clock. `pin_out` equals data AND direction, delayed by one clock, so a pin whose enable is off drives 0.
- R10: After reset all registers, all response outputs and all pin outputs are 0.
- R11: The `cfg_*` outputs show the mask A, mask B, direction, polarity, edge, both-edges and input-enable registers in the cycle after the write that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the bank |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| req_wdata | input | NPINS | Write data |
| rsp_ack | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Request was rejected |
| rsp_size_err | output | 1 | The rejection was caused by the access size |
| rsp_rdata | output | NPINS | Read data |
| pin_out | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Per-pin output enables |
| cfg_mask_a | output | NPINS | Interrupt mask A |
| cfg_mask_b | output | NPINS | Interrupt mask B |
| cfg_dir | output | NPINS | Direction (1 = output) |
| cfg_polar | output | NPINS | Polarity select |
| cfg_edge | output | NPINS | Edge (1) or level (0) trigger |
| cfg_both | output | NPINS | Trigger on both edges |
| cfg_inen | output | NPINS | Input enable |

## Verification
The bench builds the block with its defaults: NPINS=16, ADDR_W=8 and REG_OUT=1. Full 16-bit data makes every alias operation act on all bit positions. The 8-bit address reaches aligned slots above the last register and misaligned offsets, and it can combine a bad size with a bad address so that error priority can be observed. The registered output variant makes the one-cycle lag of `pin_oe` and `pin_out` behind a direction or data write visible.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // low two bits of a grouped slot select the operation
   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_CLEAR = 2'd1,
      OP_SET   = 2'd2,
      OP_FLIP  = 2'd3
   } wr_op_e;

   localparam int SLOT_SPAN    = 4;   // bytes between slots
   localparam int NUM_SLOTS    = 17;
   localparam int ALIAS_GROUPS = 3;
   localparam int ALIAS_SLOTS  = ALIAS_GROUPS * 4;
   localparam int PLAIN_REGS   = NUM_SLOTS - ALIAS_SLOTS;
   localparam int NUM_REGS     = ALIAS_GROUPS + PLAIN_REGS;

   // storage index of each register
   localparam int RI_DATA  = 0;
   localparam int RI_MASKA = 1;
   localparam int RI_MASKB = 2;
   localparam int RI_DIR   = 3;
   localparam int RI_POLAR = 4;
   localparam int RI_EDGE  = 5;
   localparam int RI_BOTH  = 6;
   localparam int RI_INEN  = 7;

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
   import gpio_rb_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SLOT_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              size_bad,
   output logic              map_bad,
   output logic              hit,
   output logic [SLOT_W-1:0] slot
);

   localparam int WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] word_idx;
   logic              aligned;
   logic              in_range;

   assign word_idx = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);
   assign in_range = (int'(word_idx) < NUM_SLOTS);

   assign size_bad = (size != SZ_HALF);
   assign map_bad  = !(aligned && in_range);
   assign hit      = !size_bad && !map_bad;
   assign slot     = word_idx[SLOT_W-1:0];

endmodule

// File: rtl/gpio_rb_alias_reg.sv
module gpio_rb_alias_reg
   import gpio_rb_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  wr_op_e       op,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         unique case (op)
            OP_WRITE: q <= wdata;
            OP_CLEAR: q <= q & ~wdata;
            OP_SET:   q <= q | wdata;
            OP_FLIP:  q <= q ^ wdata;
            default:  q <= q;
         endcase
      end
   end

endmodule

// File: rtl/gpio_rb_pindrv.sv
module gpio_rb_pindrv #(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] data,
   input  logic [W-1:0] dir,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_out <= '0;
            pin_oe  <= '0;
         end else begin
            pin_out <= data & dir;
            pin_oe  <= dir;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pin_out    = data & dir;
      assign pin_oe     = dir;
   end

endmodule

// File: rtl/gpio_rb.sv
module gpio_rb
   import gpio_rb_pkg::*;
#(
   parameter int NPINS   = 16,
   parameter int ADDR_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [NPINS-1:0]  req_wdata,
   output logic              rsp_ack,
   output logic              rsp_err,
   output logic              rsp_size_err,
   output logic [NPINS-1:0]  rsp_rdata,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  cfg_mask_a,
   output logic [NPINS-1:0]  cfg_mask_b,
   output logic [NPINS-1:0]  cfg_dir,
   output logic [NPINS-1:0]  cfg_polar,
   output logic [NPINS-1:0]  cfg_edge,
   output logic [NPINS-1:0]  cfg_both,
   output logic [NPINS-1:0]  cfg_inen
);

   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int IDX_W  = $clog2(NUM_REGS);

   if (NPINS < 1 || NPINS > 16) begin : g_bad_npins
      $error("gpio_rb: NPINS must be 1..16");
   end
   if (ADDR_W < SLOT_W + 2) begin : g_bad_addr
      $error("gpio_rb: ADDR_W too small for the slot map");
   end

   logic              size_bad;
   logic              map_bad;
   logic              acc_hit;
   logic [SLOT_W-1:0] acc_slot;
   logic              wr_fire;

   gpio_rb_decode #(
      .ADDR_W (ADDR_W),
      .SLOT_W (SLOT_W)
   ) u_decode (
      .addr     (req_addr),
      .size     (req_size),
      .size_bad (size_bad),
      .map_bad  (map_bad),
      .hit      (acc_hit),
      .slot     (acc_slot)
   );

   assign wr_fire = req_valid && req_write && acc_hit;

   logic [NPINS-1:0] reg_q  [NUM_REGS];
   logic             reg_we [NUM_REGS];
   wr_op_e           reg_op [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (r < ALIAS_GROUPS) begin : g_alias
         assign reg_we[r] = wr_fire && ((int'(acc_slot) / SLOT_SPAN) == r);
         assign reg_op[r] = wr_op_e'(acc_slot[1:0]);
      end else begin : g_plain
         assign reg_we[r] = wr_fire &&
                            (int'(acc_slot) == ALIAS_SLOTS + r - ALIAS_GROUPS);
         assign reg_op[r] = OP_WRITE;
      end

      gpio_rb_alias_reg #(
         .W (NPINS)
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (reg_we[r]),
         .op    (reg_op[r]),
         .wdata (req_wdata),
         .q     (reg_q[r])
      );
   end

   // read path: every slot of a group maps onto the group's register
   logic [IDX_W-1:0] rd_idx;
   logic [NPINS-1:0] rd_val;

   always_comb begin
      int ri;
      if (int'(acc_slot) < ALIAS_SLOTS) ri = int'(acc_slot) / SLOT_SPAN;
      else                              ri = int'(acc_slot) - ALIAS_SLOTS + ALIAS_GROUPS;
      rd_idx = ri[IDX_W-1:0];
   end

   assign rd_val = reg_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ack      <= 1'b0;
         rsp_err      <= 1'b0;
         rsp_size_err <= 1'b0;
         rsp_rdata    <= '0;
      end else begin
         rsp_ack      <= req_valid;
         rsp_err      <= req_valid && (size_bad || map_bad);
         rsp_size_err <= req_valid && size_bad;
         rsp_rdata    <= (req_valid && !req_write && acc_hit) ? rd_val : '0;
      end
   end

   gpio_rb_pindrv #(
      .W       (NPINS),
      .REG_OUT (REG_OUT)
   ) u_pindrv (
      .clk     (clk),
      .rst_n   (rst_n),
      .data    (reg_q[RI_DATA]),
      .dir     (reg_q[RI_DIR]),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   assign cfg_mask_a = reg_q[RI_MASKA];
   assign cfg_mask_b = reg_q[RI_MASKB];
   assign cfg_dir    = reg_q[RI_DIR];
   assign cfg_polar  = reg_q[RI_POLAR];
   assign cfg_edge   = reg_q[RI_EDGE];
   assign cfg_both   = reg_q[RI_BOTH];
   assign cfg_inen   = reg_q[RI_INEN];

endmodule

// File: rtl/gpio_rb_chk.sv
module gpio_rb_chk #(
   parameter int NPINS   = 16,
   parameter int ADDR_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              rsp_ack,
   input logic              rsp_err,
   input logic              rsp_size_err,
   input logic [NPINS-1:0]  rsp_rdata,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPINS-1:0]  cfg_mask_a,
   input logic [NPINS-1:0]  cfg_dir
);

   logic unmapped_half;
   assign unmapped_half = req_valid && (req_size == 2'd1) &&
                          ((req_addr[1:0] != 2'b00) || (int'(req_addr) >= 68));

   // R8
   ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_ack);

   // R8
   no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_ack);

   // R8
   err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err || rsp_size_err) |-> rsp_ack);

   // R8
   write_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0));

   // R6
   size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 2'd1) |=> (rsp_err && rsp_size_err && $stable(cfg_dir)
                                          && $stable(cfg_mask_a)));

   // R7
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_half |=> (rsp_err && !rsp_size_err && $stable(cfg_dir)
                         && $stable(cfg_mask_a)));

   // R9
   out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   if (REG_OUT) begin : g_lag
      // R9
      oe_lags_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (pin_oe == $past(cfg_dir)));
   end

endmodule

bind gpio_rb gpio_rb_chk #(
   .NPINS   (NPINS),
   .ADDR_W  (ADDR_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .req_size     (req_size),
   .rsp_ack      (rsp_ack),
   .rsp_err      (rsp_err),
   .rsp_size_err (rsp_size_err),
   .rsp_rdata    (rsp_rdata),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe),
   .cfg_mask_a   (cfg_mask_a),
   .cfg_dir      (cfg_dir)
);

// File: tb/gpio_rb_bench.sv
`timescale 1ns/1ps
module gpio_rb_bench;

   localparam int NP = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = 2'd1;
   logic [NP-1:0] req_wdata = '0;
   logic          rsp_ack, rsp_err, rsp_size_err;
   logic [NP-1:0] rsp_rdata, pin_out, pin_oe;
   logic [NP-1:0] cfg_mask_a, cfg_mask_b, cfg_dir, cfg_polar, cfg_edge, cfg_both, cfg_inen;

   always #2.5 clk = ~clk;

   gpio_rb #(.NPINS(NP), .ADDR_W(AW), .REG_OUT(1'b1)) u_gpio_rb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_size_err(rsp_size_err),
      .rsp_rdata(rsp_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
      .cfg_mask_a(cfg_mask_a), .cfg_mask_b(cfg_mask_b), .cfg_dir(cfg_dir),
      .cfg_polar(cfg_polar), .cfg_edge(cfg_edge), .cfg_both(cfg_both),
      .cfg_inen(cfg_inen));

   int n_checks = 0;
   int n_fail   = 0;
   bit model_on = 0;

   // reference state: 0 data,1 maskA,2 maskB,3 dir,4 polar,5 edge,6 both,7 inen
   logic [NP-1:0] m [8];
   logic          e_ack = 0, e_err = 0, e_serr = 0;
   logic [NP-1:0] e_rd = '0, e_out = '0, e_oe = '0;
   string         e_tag = "R10";

   task automatic chk(input string tag, input string what,
                      input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (model_on) begin
         e_oe  = m[3];
         e_out = m[0] & m[3];
         e_ack = req_valid; e_err = 0; e_serr = 0; e_rd = '0; e_tag = "R8";
         if (req_valid) begin
            if (req_size != 2'd1) begin
               e_err = 1; e_serr = 1; e_tag = "R6";
            end else if (req_addr % 4 != 0 || req_addr >= 68) begin
               e_err = 1; e_tag = "R7";
            end else begin
               int slot, idx, op;
               slot = req_addr / 4;
               idx  = (slot < 12) ? slot / 4 : slot - 9;
               op   = (slot < 12) ? slot % 4 : 0;
               if (!req_write) begin
                  e_rd = m[idx]; e_tag = (op != 0) ? "R5" : "R1";
               end else begin
                  case (op)
                     0: begin m[idx] = req_wdata;            e_tag = "R1"; end
                     1: begin m[idx] = m[idx] & ~req_wdata;  e_tag = "R2"; end
                     2: begin m[idx] = m[idx] | req_wdata;   e_tag = "R3"; end
                     default: begin m[idx] = m[idx] ^ req_wdata; e_tag = "R4"; end
                  endcase
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk(e_tag, "ack",  {15'b0, rsp_ack},      {15'b0, e_ack});
         chk(e_tag, "err",  {15'b0, rsp_err},      {15'b0, e_err});
         chk(e_tag, "serr", {15'b0, rsp_size_err}, {15'b0, e_serr});
         chk(e_tag, "rdata", rsp_rdata, e_rd);
         chk("R9", "pin_oe",  pin_oe,  e_oe);
         chk("R9", "pin_out", pin_out, e_out);
         chk("R11", "mask_a", cfg_mask_a, m[1]);
         chk("R11", "mask_b", cfg_mask_b, m[2]);
         chk("R11", "dir",    cfg_dir,    m[3]);
         chk("R11", "polar",  cfg_polar,  m[4]);
         chk("R11", "edge",   cfg_edge,   m[5]);
         chk("R11", "both",   cfg_both,   m[6]);
         chk("R11", "inen",   cfg_inen,   m[7]);
      end
   end

   task automatic acc(input bit wr, input int addr, input int sz, input int wd);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = addr[AW-1:0];
      req_size = sz[1:0]; req_wdata = wd[NP-1:0];
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      n_checks++; n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      chk("R10", "ack",     {15'b0, rsp_ack}, 16'h0);
      chk("R10", "rdata",   rsp_rdata, 16'h0);
      chk("R10", "pin_oe",  pin_oe, 16'h0);
      chk("R10", "pin_out", pin_out, 16'h0);
      chk("R10", "dir",     cfg_dir, 16'h0);
      model_on = 1;
      idle(2);
      // R1 plain writes and R9 lag
      acc(1, 8'h30, 1, 16'h00FF);
      acc(1, 8'h00, 1, 16'hA5A5);
      acc(0, 8'h00, 1, 0);
      // R3 / R2 / R4 on data
      acc(1, 8'h08, 1, 16'h0F00);
      acc(1, 8'h04, 1, 16'h00F0);
      acc(1, 8'h0C, 1, 16'hFFFF);
      // R5 alias reads
      acc(0, 8'h04, 1, 0); acc(0, 8'h08, 1, 0); acc(0, 8'h0C, 1, 0);
      // mask groups
      acc(1, 8'h10, 1, 16'h1234); acc(1, 8'h14, 1, 16'h0204);
      acc(1, 8'h18, 1, 16'h8000); acc(1, 8'h1C, 1, 16'h00FF);
      acc(0, 8'h1C, 1, 0);
      acc(1, 8'h20, 1, 16'hFFFF); acc(1, 8'h24, 1, 16'hF0F0);
      acc(1, 8'h2C, 1, 16'h1111); acc(1, 8'h28, 1, 16'h0001);
      acc(0, 8'h24, 1, 0);
      // plain config registers
      acc(1, 8'h34, 1, 16'hAAAA); acc(1, 8'h38, 1, 16'h5555);
      acc(1, 8'h3C, 1, 16'hC3C3); acc(1, 8'h40, 1, 16'h7E7E);
      acc(0, 8'h34, 1, 0); acc(0, 8'h40, 1, 0);
      // R6 size errors, including combined with unmapped address
      acc(1, 8'h30, 0, 16'hFFFF); acc(1, 8'h30, 2, 16'hFFFF);
      acc(0, 8'h00, 3, 0); acc(1, 8'h50, 2, 16'h1);
      // R7 unmapped / misaligned
      acc(1, 8'h44, 1, 16'hFFFF); acc(1, 8'h02, 1, 16'hFFFF);
      acc(0, 8'hFC, 1, 0); acc(1, 8'h13, 1, 16'h1);
      // back-to-back accesses
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 8'h30; req_size = 1; req_wdata = 16'hFF00;
      @(negedge clk);
      req_addr = 8'h0C; req_wdata = 16'h0FF0;
      @(negedge clk);
      req_write = 0; req_addr = 8'h00;
      @(negedge clk);
      req_valid = 0;
      idle(2);
      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         int a, s;
         a = $urandom_range(0, 19) * 4;
         if ($urandom_range(0, 9) == 0) a = a + $urandom_range(1, 3);
         s = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 3) : 1;
         acc($urandom_range(0, 1) == 1, a, s, $urandom_range(0, 16'hFFFF));
      end
      idle(3);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule